// File: doc/BRIEF.md
# Multi-resolution adjustable real-time counter

This block keeps a free-running 53-bit time count whose least significant bit stands for 250 ns. A low-frequency tick enable advances it by a fixed step. Software reads the time through four 32-bit windows cut from different bit ranges of the same count. Each window gives up range for resolution or resolution for range.

Software can restart the count from zero with a one-cycle clear pulse. It can also move the count forward or backward with a signed delta word. Bit 31 of that word picks the scale: either single 250 ns units or steps of 2^22 units, which is about 1.049 s. A halt-enable control bit lets a core-halted input freeze the tick advance while a debugger holds the processor.

Top module: `rtc_slice_timer`

## Requirements
- R1: After rst_n is low, all four views read zero.
- R2: In count bit numbering, where count bit 0 weighs 250 ns, view_fine is count[31:0], view_micro is count[33:2], view_mid is count[36:5] and view_coarse is count[52:21].
- R3: A cycle with tick_en high and no freeze adds TICK_STEP (default 2) to the count on the next edge.
- R4: With tick_en low and no clear or delta, the count keeps its value.
- R5: When halt_en and core_halted are both high, ticks are ignored. Either signal alone does not stop counting.
- R6: clr_pulse high sets the count to zero on the next edge, even when a tick comes in the same cycle.
- R7: A delta_wr cycle whose delta_word[31] is 0 adds delta_word[30:0], taken as a signed two's-complement value, to the count.
- R8: A delta_wr cycle whose delta_word[31] is 1 adds that signed value multiplied by 2^22.
- R9: All additions wrap modulo 2^53.
- R10: A delta and a tick in the same cycle are both applied.
- R11: A clear and a delta in the same cycle give zero, because the clear wins.
- R12: A delta is still applied while the tick is frozen by halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Low-frequency tick enable, one cycle per tick |
| clr_pulse | input | 1 | Restart-to-zero request |
| delta_wr | input | 1 | Delta adjustment strobe |
| delta_word | input | 32 | Bit 31 is the scale select; bits 30:0 are the signed amount |
| halt_en | input | 1 | Lets core_halted freeze the tick |
| core_halted | input | 1 | Processor-halted indication |
| view_fine | output | 32 | 250 ns resolution window |
| view_micro | output | 32 | 1 us resolution window |
| view_mid | output | 32 | 8 us resolution window |
| view_coarse | output | 32 | About 0.5 s resolution window |

## Verification
The assertions expect every control input to be a clean synchronous level that is sampled once per clock. They treat clr_pulse and delta_wr as single-cycle requests, and they take any value of delta_word as legal. The stimulus drives all inputs on the falling edge. It mixes random tick, halt, delta and clear patterns, including cases where a clear and a delta land in the same cycle. Directed cases take the count below zero so that it wraps.

// File: rtl/rtc_slice_pkg.sv
package rtc_slice_pkg;
  localparam int unsigned VIEW_CNT = 4;
  // lowest count bit feeding each window: fine, micro, mid, coarse
  localparam int unsigned VIEW_LSB [VIEW_CNT] = '{0, 2, 5, 21};

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_ADD   = 2'd1,
    UPD_CLEAR = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/rtc_delta_scale.sv
module rtc_delta_scale #(
  parameter int unsigned CNT_W     = 53,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned EXP_SHIFT = 22
) (
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  delta
);
  localparam int unsigned MANT_W = WORD_W - 1;

  // sign-extend the mantissa, then scale it when the exponent bit is set
  function automatic logic [CNT_W-1:0] scale_delta(input logic [WORD_W-1:0] w);
    logic [CNT_W-1:0] ext;
    ext = {{(CNT_W-MANT_W){w[MANT_W-1]}}, w[MANT_W-1:0]};
    if (w[WORD_W-1]) ext = ext << EXP_SHIFT;
    return ext;
  endfunction

  assign delta = scale_delta(word);
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core
  import rtc_slice_pkg::*;
#(
  parameter int unsigned CNT_W     = 53,
  parameter int unsigned TICK_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             advance,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(TICK_STEP);

  upd_kind_e        kind;
  logic [CNT_W-1:0] step_term;
  logic [CNT_W-1:0] add_term;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (clr)                    kind = UPD_CLEAR;
    else if (add_en || advance) kind = UPD_ADD;
    else                        kind = UPD_HOLD;
  end

  assign step_term = advance ? STEP : '0;
  assign add_term  = add_en  ? add_val : '0;

  always_comb begin
    unique case (kind)
      UPD_CLEAR: cnt_nxt = '0;
      UPD_ADD:   cnt_nxt = cnt + add_term + step_term;
      default:   cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R6
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_en && advance) |=> cnt == $past(cnt) + STEP); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_en && !advance) |=> $stable(cnt)); // R4
  AST_ADD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && add_en) |=> cnt == $past(cnt) + $past(add_val) + ($past(advance) ? STEP : '0)); // R10
endmodule

// File: rtl/rtc_view_slicer.sv
module rtc_view_slicer
  import rtc_slice_pkg::*;
#(
  parameter int unsigned CNT_W  = 53,
  parameter int unsigned VIEW_W = 32
) (
  input  logic [CNT_W-1:0]  cnt,
  output logic [VIEW_W-1:0] views [VIEW_CNT]
);
  for (genvar g = 0; g < VIEW_CNT; g++) begin : g_view
    localparam int unsigned LO = VIEW_LSB[g];
    assign views[g] = cnt[LO +: VIEW_W];
  end
endmodule

// File: rtl/rtc_slice_timer.sv
module rtc_slice_timer
  import rtc_slice_pkg::*;
#(
  parameter int unsigned CNT_W     = 53,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned VIEW_W    = 32,
  parameter int unsigned EXP_SHIFT = 22,
  parameter int unsigned TICK_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              clr_pulse,
  input  logic              delta_wr,
  input  logic [WORD_W-1:0] delta_word,
  input  logic              halt_en,
  input  logic              core_halted,
  output logic [VIEW_W-1:0] view_fine,
  output logic [VIEW_W-1:0] view_micro,
  output logic [VIEW_W-1:0] view_mid,
  output logic [VIEW_W-1:0] view_coarse
);
  // named internal events
  logic             frozen;
  logic             advance;
  logic [CNT_W-1:0] delta_scaled;
  logic [CNT_W-1:0] cnt;
  logic [VIEW_W-1:0] views [VIEW_CNT];

  assign frozen  = halt_en && core_halted;
  assign advance = tick_en && !frozen;

  rtc_delta_scale #(
    .CNT_W(CNT_W), .WORD_W(WORD_W), .EXP_SHIFT(EXP_SHIFT)
  ) u_delta (
    .word (delta_word),
    .delta(delta_scaled)
  );

  rtc_count_core #(
    .CNT_W(CNT_W), .TICK_STEP(TICK_STEP)
  ) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_pulse),
    .advance(advance),
    .add_en (delta_wr),
    .add_val(delta_scaled),
    .cnt    (cnt)
  );

  rtc_view_slicer #(
    .CNT_W(CNT_W), .VIEW_W(VIEW_W)
  ) u_views (
    .cnt  (cnt),
    .views(views)
  );

  assign view_fine   = views[0];
  assign view_micro  = views[1];
  assign view_mid    = views[2];
  assign view_coarse = views[3];

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_en && core_halted && !delta_wr && !clr_pulse) |=> $stable(view_fine) && $stable(view_coarse)); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && delta_wr) |=> (view_fine == '0) && (view_coarse == '0)); // R11
endmodule

// File: tb/test_rtc_slice_timer.sv
module test_rtc_slice_timer;
  localparam int unsigned STEP = 2;
  localparam longint unsigned MASK53 = (64'd1 << 53) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, clr_pulse = 1'b0, delta_wr = 1'b0;
  logic [31:0] delta_word = '0;
  logic        halt_en = 1'b0, core_halted = 1'b0;
  logic [31:0] view_fine, view_micro, view_mid, view_coarse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  longint unsigned model = 0;

  always #4 clk = ~clk;

  rtc_slice_timer #(.TICK_STEP(STEP)) i_rtc_slice_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr_pulse(clr_pulse),
    .delta_wr(delta_wr), .delta_word(delta_word), .halt_en(halt_en),
    .core_halted(core_halted), .view_fine(view_fine), .view_micro(view_micro),
    .view_mid(view_mid), .view_coarse(view_coarse)
  );

  function automatic longint signed delta_of(input logic [31:0] w);
    logic signed [30:0] m;
    longint signed d;
    m = w[30:0];
    d = longint'(m);
    if (w[31]) d = d * 64'sd4194304;
    return d;
  endfunction

  function automatic logic [31:0] win(input longint unsigned c, input int lo);
    return 32'((c & MASK53) >> lo);
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "fine",   view_fine,   win(model, 0));
    check(tag, "micro",  view_micro,  win(model, 2));
    check(tag, "mid",    view_mid,    win(model, 5));
    check(tag, "coarse", view_coarse, win(model, 21));
  endtask

  task automatic cyc(input bit tk, input bit cl, input bit dw, input logic [31:0] word,
                     input bit he, input bit ch, input string tag);
    @(negedge clk);
    tick_en = tk; clr_pulse = cl; delta_wr = dw; delta_word = word;
    halt_en = he; core_halted = ch;
    if (cl) model = 0;
    else begin
      if (dw) model = model + longint'(unsigned'(delta_of(word)));
      if (tk && !(he && ch)) model = model + STEP;
      model = model & MASK53;
    end
    @(posedge clk);
    #1;
    check_all(tag);
    tick_en = 0; clr_pulse = 0; delta_wr = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk); rst_n = 1'b1;

    cyc(1, 0, 0, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, 1, 1, "R5");
    cyc(1, 0, 0, 0, 1, 0, "R5");
    cyc(1, 0, 0, 0, 0, 1, "R5");
    cyc(1, 0, 1, 32'h0000_1000, 1, 1, "R12");
    cyc(0, 0, 1, 32'h0123_4567, 0, 0, "R7");
    cyc(0, 0, 1, 32'h7FFF_FFF0, 0, 0, "R7");
    cyc(0, 0, 1, 32'h8000_0005, 0, 0, "R8");
    cyc(1, 0, 1, 32'h0000_0100, 0, 0, "R10");
    cyc(0, 0, 1, 32'h8ABC_DEF1, 0, 0, "R2");
    cyc(1, 1, 0, 0, 0, 0, "R6");
    cyc(0, 1, 1, 32'h0000_0777, 0, 0, "R11");
    cyc(0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R9");
    cyc(1, 0, 0, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, 0, 0, "R6");
    cyc(0, 0, 1, 32'h7FFF_FFFF, 0, 0, "R9");
    cyc(1, 0, 1, 32'h8000_0002, 0, 0, "R9");

    for (int i = 0; i < 4000; i++) begin
      bit tk, cl, dw, he, ch;
      logic [31:0] w;
      string tag;
      tk = ($urandom_range(3) != 0);
      cl = ($urandom_range(63) == 0);
      dw = ($urandom_range(7) == 0);
      he = $urandom_range(1);
      ch = $urandom_range(1);
      w  = $urandom;
      if (cl && dw) tag = "R11";
      else if (cl) tag = "R6";
      else if (dw && w[31]) tag = "R8";
      else if (dw) tag = "R7";
      else if (he && ch) tag = "R5";
      else tag = "R3";
      cyc(tk, cl, dw, w, he, ch, tag);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule